// File: doc/BRIEF.md
# Circular-Buffer Audio Ring DMA

This block carries audio bytes between a local byte FIFO and system memory, one fixed-size burst per memory transaction. Memory is treated as a ring. The pointer walks upward from a programmable base. After it has served the burst that sits at a programmable last-burst address, it returns to the base. One variant can instead begin at a separate initial address, so a stream can start part way into the ring.

Software programs the block through a small register file of 32-bit words. A byte offset selects the word, and offsets go up in steps of four. A period counter raises a repeating interrupt every N granted bursts. A second source flags an audio-side overrun: a byte pushed while the FIFO is full (capture), or a byte popped while it is empty (playback). Sources are latched as pending. They are removed by holding a clear mask, and the mask must be lowered again before they can latch once more. A select field chooses what the second status word shows. One choice gives the live memory pointer, from which software derives the stream position.

The FIFO asks for a memory burst once enough bytes have built up to reach the programmed threshold. In capture this is the fill level; in playback it is the free space. Clearing the enable bit stops the engine and empties the FIFO, but it keeps every programmed address.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset, mem_req and irq are 0, and the control, pending-status, base-address and second-status words all read 0.
- R2: While disabled, the pointer holds the initial-address word (offset 0x10). The first burst after enable is issued at that address.
- R3: Each granted burst moves the pointer up by BURST_BYTES. The burst granted at the last-burst address (offset 0x0C) is followed by one at the base address (offset 0x08).
- R4: Pending bit 0 is set on every Nth granted burst, where N is the period word at offset 0x14. A period of 0 never sets it.
- R5: In capture mode, mem_req rises once the fill level reaches min((V+1)*BURST_BYTES, DEPTH_BYTES). V is the threshold word at offset 0x18.
- R6: mem_req stays high until mem_gnt is seen. Each grant removes one burst, and mem_wdata carries the oldest pushed byte in bits [7:0].
- R7: Writing 0 to enable bit 0 of the control word (offset 0x00) drops mem_req within one cycle. It also empties the FIFO and zeroes the period counter, but leaves the address words unchanged.
- R8: Bits [1:0] of the word at offset 0x04 form a clear mask. While a mask bit is 1, that pending bit reads 0 and cannot be set. Once the bit returns to 0, the source can latch again.
- R9: A byte pushed while the FIFO holds DEPTH_BYTES bytes and the engine is enabled is discarded, and it sets pending bit 1.
- R10: irq is the OR of the pending bits (offset 0x1C, bits [1:0]) ANDed with the interrupt enables in control-word bits [9:8].
- R11: Select bits [5:4] of the word at offset 0x04 choose the second status word (offset 0x20): 0 gives the current pointer, 1 gives the FIFO level in bytes, 2 gives the period counter and 3 gives zero.
- R12: The address words store their writes with the bits below log2(BURST_BYTES) forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | Burst request to memory |
| mem_gnt | input | 1 | Burst grant; one burst completes per cycle in which it is high with mem_req |
| mem_addr | output | AW | Byte address of the requested burst |
| mem_wdata | output | BURST_BYTES*8 | Burst data toward memory (capture) |
| mem_rdata | input | BURST_BYTES*8 | Burst data from memory (playback) |
| aud_push | input | 1 | Push one audio byte (capture) |
| aud_wbyte | input | 8 | Byte to push |
| aud_pop | input | 1 | Pop one audio byte (playback) |
| aud_rbyte | output | 8 | Byte at the FIFO head |
| aud_full | output | 1 | FIFO holds DEPTH_BYTES bytes |
| aud_empty | output | 1 | FIFO is empty |

## Verification
The assertions rely on three conditions at the inputs. The memory side grants only while a request is shown. The last-burst and base addresses lie on a common grid, with the last-burst address at or above the base. Software writes the period and threshold words only while the engine is disabled. The stimulus grants one burst at a time, and only after it has observed mem_req. It places the last-burst address exactly two bursts above the base. It reprograms the period and threshold only after clearing the enable bit.

// File: rtl/audma_pkg.sv
package audma_pkg;

  // Word indices within the register file (byte offset = index * 4)
  localparam logic [3:0] IDX_CTRL   = 4'd0;
  localparam logic [3:0] IDX_CTRL1  = 4'd1;
  localparam logic [3:0] IDX_BASE   = 4'd2;
  localparam logic [3:0] IDX_LAST   = 4'd3;
  localparam logic [3:0] IDX_INIT   = 4'd4;
  localparam logic [3:0] IDX_PERIOD = 4'd5;
  localparam logic [3:0] IDX_THRESH = 4'd6;
  localparam logic [3:0] IDX_PEND   = 4'd7;
  localparam logic [3:0] IDX_STAT2  = 4'd8;

  localparam int IRQ_N      = 2;
  localparam int IRQ_PERIOD = 0;
  localparam int IRQ_XRUN   = 1;

  typedef enum logic [1:0] {
    VIEW_ADDR  = 2'd0,
    VIEW_LEVEL = 2'd1,
    VIEW_COUNT = 2'd2,
    VIEW_ZERO  = 2'd3
  } stat_view_e;

  // Request threshold in bytes: (v+1) bursts, clamped to the FIFO depth
  function automatic int thr_bytes(input int v, input int burst, input int depth);
    int t;
    t = (v + 1) * burst;
    return (t > depth) ? depth : t;
  endfunction

endpackage

// File: rtl/audma_regs.sv
module audma_regs
  import audma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int RAW   = 6,
  parameter int ALIGN = 3,
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RAW-1:0]    addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              en,
  output logic [IRQ_N-1:0]  irq_en,
  output logic [IRQ_N-1:0]  clr,
  output stat_view_e        view,
  output logic [AW-1:0]     base_addr,
  output logic [AW-1:0]     last_addr,
  output logic [AW-1:0]     init_addr,
  output logic [CNT_W-1:0]  period,
  output logic [THR_W-1:0]  thresh,
  input  logic [IRQ_N-1:0]  pend,
  input  logic [31:0]       stat2
);

  logic [3:0] idx;
  assign idx = addr[5:2];

  function automatic logic [AW-1:0] align_addr(input logic [31:0] d);
    return {d[AW-1:ALIGN], {ALIGN{1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      irq_en    <= '0;
      clr       <= '0;
      view      <= VIEW_ADDR;
      base_addr <= '0;
      last_addr <= '0;
      init_addr <= '0;
      period    <= '0;
      thresh    <= '0;
    end else if (wr) begin
      case (idx)
        IDX_CTRL: begin
          en     <= wdata[0];
          irq_en <= wdata[9:8];
        end
        IDX_CTRL1: begin
          clr  <= wdata[1:0];
          view <= stat_view_e'(wdata[5:4]);
        end
        IDX_BASE:   base_addr <= align_addr(wdata);
        IDX_LAST:   last_addr <= align_addr(wdata);
        IDX_INIT:   init_addr <= align_addr(wdata);
        IDX_PERIOD: period    <= wdata[CNT_W-1:0];
        IDX_THRESH: thresh    <= wdata[THR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_CTRL:   rdata = {22'd0, irq_en, 7'd0, en};
      IDX_CTRL1:  rdata = {26'd0, view, 2'd0, clr};
      IDX_BASE:   rdata = 32'(base_addr);
      IDX_LAST:   rdata = 32'(last_addr);
      IDX_INIT:   rdata = 32'(init_addr);
      IDX_PERIOD: rdata = 32'(period);
      IDX_THRESH: rdata = 32'(thresh);
      IDX_PEND:   rdata = 32'(pend);
      IDX_STAT2:  rdata = stat2;
      default:    rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/audma_walker.sv
module audma_walker #(
  parameter int AW       = 32,
  parameter int BURST    = 8,
  parameter int CNT_W    = 16,
  parameter bit USE_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             adv,
  input  logic [AW-1:0]    base_addr,
  input  logic [AW-1:0]    last_addr,
  input  logic [AW-1:0]    init_addr,
  input  logic [CNT_W-1:0] period,
  output logic [AW-1:0]    cur_addr,
  output logic [CNT_W-1:0] bcount,
  output logic             period_hit
);

  localparam logic [AW-1:0] STEP = AW'(BURST);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] cur,
                                             input logic [AW-1:0] base,
                                             input logic [AW-1:0] last);
    return (cur == last) ? base : cur + STEP;
  endfunction

  function automatic logic reaches(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] per);
    return (per != '0) && ((cnt + 1'b1) >= per);
  endfunction

  logic [AW-1:0] idle_addr;

  generate
    if (USE_INIT) begin : g_init
      assign idle_addr = init_addr;
    end else begin : g_base
      assign idle_addr = base_addr;
    end
  endgenerate

  assign period_hit = en && adv && reaches(bcount, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      bcount   <= '0;
    end else if (!en) begin
      cur_addr <= idle_addr;
      bcount   <= '0;
    end else if (adv) begin
      cur_addr <= next_ptr(cur_addr, base_addr, last_addr);
      bcount   <= reaches(bcount, period) ? '0 : bcount + 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && cur_addr != last_addr) |=> (cur_addr == $past(cur_addr) + STEP)); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && cur_addr == last_addr) |=> (cur_addr == $past(base_addr))); // R3
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (bcount == '0)); // R7

endmodule

// File: rtl/audma_byte_fifo.sv
module audma_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int BURST = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       byte_wr,
  input  logic [7:0]                 byte_din,
  input  logic                       byte_rd,
  output logic [7:0]                 byte_dout,
  input  logic                       burst_wr,
  input  logic [BURST*8-1:0]         burst_din,
  input  logic                       burst_rd,
  output logic [BURST*8-1:0]         burst_dout,
  output logic [$clog2(DEPTH):0]     level
);

  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;
  localparam logic [LW-1:0] BSTEP = LW'(BURST);
  localparam logic [LW-1:0] ONE   = LW'(1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] in_n, out_n;

  assign in_n  = byte_wr ? ONE : (burst_wr ? BSTEP : '0);
  assign out_n = byte_rd ? ONE : (burst_rd ? BSTEP : '0);

  always_ff @(posedge clk) begin
    if (byte_wr) mem[wr_ptr] <= byte_din;
    if (burst_wr) begin
      for (int k = 0; k < BURST; k++) mem[wr_ptr + PW'(k)] <= burst_din[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + in_n[PW-1:0];
      rd_ptr <= rd_ptr + out_n[PW-1:0];
      level  <= level + in_n - out_n;
    end
  end

  assign byte_dout = mem[rd_ptr];

  generate
    for (genvar g = 0; g < BURST; g++) begin : g_lane
      assign burst_dout[8*g +: 8] = mem[rd_ptr + PW'(g)];
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_rd && !flush) |-> (level >= BSTEP)); // R6

endmodule

// File: rtl/audma_irq.sv
module audma_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic         irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend | ev) & ~clr;
  end

  assign irq = |(pend & mask);

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clr[i] |=> !pend[i]); // R8
      AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[i] && !clr[i]) |=> pend[i]); // R4
    end
  endgenerate

endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
  import audma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int RAW         = 6,
  parameter int BURST_BYTES = 8,
  parameter int DEPTH_BYTES = 256,
  parameter int CNT_W       = 16,
  parameter int THR_W       = 8,
  parameter bit CAPTURE     = 1'b1,
  parameter bit HAS_INIT    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [RAW-1:0]           reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     irq,
  output logic                     mem_req,
  input  logic                     mem_gnt,
  output logic [AW-1:0]            mem_addr,
  output logic [BURST_BYTES*8-1:0] mem_wdata,
  input  logic [BURST_BYTES*8-1:0] mem_rdata,
  input  logic                     aud_push,
  input  logic [7:0]               aud_wbyte,
  input  logic                     aud_pop,
  output logic [7:0]               aud_rbyte,
  output logic                     aud_full,
  output logic                     aud_empty
);

  localparam int ALIGN = $clog2(BURST_BYTES);
  localparam int LW    = $clog2(DEPTH_BYTES) + 1;

  logic              en;
  logic [IRQ_N-1:0]  irq_en, clr, pend, ev;
  stat_view_e        view;
  logic [AW-1:0]     base_addr, last_addr, init_addr, cur_addr;
  logic [CNT_W-1:0]  period, bcount;
  logic [THR_W-1:0]  thresh;
  logic [31:0]       stat2;
  logic [LW-1:0]     level;
  logic              period_hit, grant, ready, req_q;
  logic              byte_wr, byte_rd, burst_wr, burst_rd, xrun;
  int                thr_b, avail;

  audma_regs #(.AW(AW), .RAW(RAW), .ALIGN(ALIGN), .CNT_W(CNT_W), .THR_W(THR_W)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .en, .irq_en, .clr, .view, .base_addr, .last_addr, .init_addr, .period, .thresh,
    .pend, .stat2
  );

  audma_walker #(.AW(AW), .BURST(BURST_BYTES), .CNT_W(CNT_W), .USE_INIT(HAS_INIT)) u_walk (
    .clk, .rst_n, .en, .adv(grant), .base_addr, .last_addr, .init_addr, .period,
    .cur_addr, .bcount, .period_hit
  );

  // Direction-dependent steering of the FIFO ports
  assign aud_full  = (level == LW'(DEPTH_BYTES));
  assign aud_empty = (level == '0);
  assign grant     = req_q && mem_gnt && en;
  assign byte_wr   = CAPTURE  && en && aud_push && !aud_full;
  assign byte_rd   = !CAPTURE && en && aud_pop  && !aud_empty;
  assign burst_rd  = CAPTURE  && grant;
  assign burst_wr  = !CAPTURE && grant;
  assign xrun      = en && (CAPTURE ? (aud_push && aud_full) : (aud_pop && aud_empty));

  audma_byte_fifo #(.DEPTH(DEPTH_BYTES), .BURST(BURST_BYTES)) u_fifo (
    .clk, .rst_n, .flush(!en),
    .byte_wr, .byte_din(aud_wbyte), .byte_rd, .byte_dout(aud_rbyte),
    .burst_wr, .burst_din(mem_rdata), .burst_rd, .burst_dout(mem_wdata),
    .level
  );

  // Threshold: fill level for capture, free space for playback
  assign thr_b = thr_bytes(int'(thresh), BURST_BYTES, DEPTH_BYTES);
  assign avail = CAPTURE ? int'(level) : (DEPTH_BYTES - int'(level));
  assign ready = (avail >= thr_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              req_q <= 1'b0;
    else if (!en)            req_q <= 1'b0;
    else if (req_q)          req_q <= !mem_gnt;
    else if (ready)          req_q <= 1'b1;
  end

  assign mem_req  = req_q;
  assign mem_addr = cur_addr;

  always_comb begin
    ev = '0;
    ev[IRQ_PERIOD] = period_hit;
    ev[IRQ_XRUN]   = xrun;
  end

  audma_irq #(.N(IRQ_N)) u_irq (
    .clk, .rst_n, .ev, .clr, .mask(irq_en), .pend, .irq
  );

  always_comb begin
    case (view)
      VIEW_ADDR:  stat2 = 32'(cur_addr);
      VIEW_LEVEL: stat2 = 32'(level);
      VIEW_COUNT: stat2 = 32'(bcount);
      default:    stat2 = 32'd0;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && en) |=> (mem_req || !en)); // R6
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mem_req); // R7
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ALIGN-1:0] == '0)); // R12

endmodule

// File: tb/tb_audio_ring_dma.sv
module tb_audio_ring_dma;

  localparam int CLK_NS = 10;
  localparam int BB     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, aud_full, aud_empty;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        aud_push = 1'b0, aud_pop = 1'b0;
  logic [7:0]  aud_wbyte = '0, aud_rbyte;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int next_byte = 0;

  always #(CLK_NS/2) clk = ~clk;

  audio_ring_dma dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .mem_req, .mem_gnt, .mem_addr, .mem_wdata, .mem_rdata,
    .aud_push, .aud_wbyte, .aud_pop, .aud_rbyte, .aud_full, .aud_empty
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      aud_push = 1'b1; aud_wbyte = 8'(next_byte);
      next_byte++;
    end
    @(negedge clk);
    aud_push = 1'b0;
  endtask

  function automatic logic [63:0] burst_of(input int b);
    logic [63:0] v;
    for (int k = 0; k < BB; k++) v[8*k +: 8] = 8'(b + k);
    return v;
  endfunction

  task automatic wait_req(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      seen = mem_req;
    end
  endtask

  task automatic grant_one(input string tag, input logic [31:0] exp_addr, input int first_byte);
    bit seen;
    wait_req(seen);
    check({tag, " request seen"}, 64'(seen), 64'd1);
    check({tag, " burst address"}, 64'(mem_addr), 64'(exp_addr));
    check({tag, " burst data"}, mem_wdata, burst_of(first_byte));
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    logic [31:0] d;
    check("R1 mem_req", 64'(mem_req), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    rd(6'h00, d); check("R1 control word", 64'(d), 64'd0);
    rd(6'h1C, d); check("R1 pending word", 64'(d), 64'd0);
    rd(6'h08, d); check("R1 base word", 64'(d), 64'd0);
    rd(6'h20, d); check("R1 second status", 64'(d), 64'd0);
  endtask

  // R12: alignment of address words
  task automatic t_align();
    logic [31:0] d;
    wr(6'h08, 32'h0000_1003);
    rd(6'h08, d); check("R12 base low bits dropped", 64'(d), 64'h1000);
    wr(6'h0C, 32'h0000_1017);
    rd(6'h0C, d); check("R12 last low bits dropped", 64'(d), 64'h1010);
  endtask

  // R2 R3 R4 R6 R8 R10 R11: ring walk, period interrupt, clear
  task automatic t_ring();
    logic [31:0] d;
    wr(6'h10, 32'h1008);
    wr(6'h14, 32'd2);
    wr(6'h18, 32'd0);
    wr(6'h04, 32'h0);
    rd(6'h20, d); check("R2 idle pointer follows initial word", 64'(d), 64'h1008);
    wr(6'h00, 32'h101);
    push(32);
    idle(4);
    check("R6 request held without grant", 64'(mem_req), 64'd1);
    grant_one("R2 first burst", 32'h1008, 0);
    rd(6'h1C, d); check("R4 no period yet", 64'(d), 64'd0);
    grant_one("R3 step", 32'h1010, 8);
    rd(6'h1C, d); check("R4 period pending", 64'(d), 64'd1);
    check("R10 irq with enabled pending", 64'(irq), 64'd1);
    grant_one("R3 wrap to base", 32'h1000, 16);
    wr(6'h04, 32'h21);
    rd(6'h20, d); check("R11 period counter view", 64'(d), 64'd1);
    idle(1);
    rd(6'h1C, d); check("R8 cleared by mask", 64'(d), 64'd0);
    check("R10 irq low after clear", 64'(irq), 64'd0);
    grant_one("R3 after wrap", 32'h1008, 24);
    rd(6'h1C, d); check("R8 masked source stays clear", 64'(d), 64'd0);
    wr(6'h04, 32'h20);
    rd(6'h20, d); check("R11 counter restarted", 64'(d), 64'd0);
    idle(3);
    check("R5 no request when FIFO empty", 64'(mem_req), 64'd0);
    push(16);
    grant_one("R3 continue", 32'h1010, 32);
    grant_one("R3 wrap again", 32'h1000, 40);
    rd(6'h1C, d); check("R8 source latches after mask lowered", 64'(d), 64'd1);
  endtask

  // R5 R7 R9 R10 R11: disable, threshold, clamp, overrun
  task automatic t_thresh();
    logic [31:0] d;
    bit seen;
    push(4);
    wr(6'h04, 32'h10);
    rd(6'h20, d); check("R11 level view", 64'(d), 64'd4);
    wr(6'h00, 32'h0);
    idle(1);
    rd(6'h20, d); check("R7 FIFO emptied on disable", 64'(d), 64'd0);
    rd(6'h08, d); check("R7 base kept", 64'(d), 64'h1000);
    rd(6'h0C, d); check("R7 last kept", 64'(d), 64'h1010);
    wr(6'h04, 32'h13);
    wr(6'h04, 32'h10);
    wr(6'h18, 32'd1);
    wr(6'h00, 32'h1);
    next_byte = 100;
    push(8);
    idle(4);
    check("R5 below two-burst threshold", 64'(mem_req), 64'd0);
    push(8);
    grant_one("R5 threshold reached, R2 restart at initial", 32'h1008, 100);
    idle(3);
    check("R5 level back below threshold", 64'(mem_req), 64'd0);
    wr(6'h00, 32'h0);
    wr(6'h18, 32'd63);
    wr(6'h00, 32'h1);
    push(255);
    idle(4);
    check("R5 clamp not yet reached", 64'(mem_req), 64'd0);
    rd(6'h20, d); check("R11 level 255", 64'(d), 64'd255);
    push(1);
    wait_req(seen);
    check("R5 clamped threshold equals depth", 64'(seen), 64'd1);
    check("R9 full flag", 64'(aud_full), 64'd1);
    push(1);
    rd(6'h1C, d); check("R9 overrun pending", 64'(d), 64'd2);
    rd(6'h20, d); check("R9 byte discarded", 64'(d), 64'd256);
    check("R10 overrun masked", 64'(irq), 64'd0);
    wr(6'h00, 32'h201);
    check("R10 overrun enabled", 64'(irq), 64'd1);
    wr(6'h04, 32'h30);
    rd(6'h20, d); check("R11 zero view", 64'(d), 64'd0);
    wr(6'h00, 32'h0);
    idle(1);
    check("R7 request dropped", 64'(mem_req), 64'd0);
  endtask

  // R4: period zero never fires
  task automatic t_period_zero();
    logic [31:0] d;
    wr(6'h14, 32'd0);
    wr(6'h18, 32'd0);
    wr(6'h04, 32'h03);
    wr(6'h04, 32'h00);
    wr(6'h00, 32'h101);
    next_byte = 0;
    push(24);
    grant_one("R4 p0 a", 32'h1008, 0);
    grant_one("R4 p0 b", 32'h1010, 8);
    grant_one("R4 p0 c", 32'h1000, 16);
    rd(6'h1C, d); check("R4 period 0 never pends", 64'(d), 64'd0);
    check("R4 irq stays low", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_align();
    t_ring();
    t_thresh();
    t_period_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule